// File: doc/BRIEF.md
# Edge-Slip Frequency Steering and Lock Monitor

This block compares two divided-down square waves in a frequency synthesizer loop: a reference tick and a tick derived from the oscillator under control. It is a purely digital comparator that runs on a fast system clock. Both inputs are brought into the clock domain through two-flop synchronizers, and their rising edges are detected there. The block then tracks how the edges of the two signals interleave.

While the loop is locked, the edges alternate and the block stays quiet. The steering output is released (output enable low) and the lock flag is high. When one signal produces two rising edges with no edge of the other in between, an edge has slipped. The steering output is then driven for one measured reference period. It is driven low if the oscillator side is too fast and high if it is too slow. While the steering output is driven, the lock flag is low. Because a slip happens about once per beat between the two signals, the pulses repeat at roughly the difference frequency.

The block also produces a charge window. This window opens at each reference edge and closes at the next oscillator edge, so a downstream analog stage can use it to gate its ramp.

Top module: `pll_slip_monitor`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, steerOe is 0, lockOut is 1 and chargeOut is 0.
- R2: Two synchronized oscillator rising edges with no reference rising edge between them form a fast slip. On the clock edge that registers the second of those oscillator edges, steerOe becomes 1 and steerLevel becomes 0.
- R3: Two synchronized reference rising edges with no oscillator rising edge between them form a slow slip. On the clock edge that registers the second of those reference edges, steerOe becomes 1 and steerLevel becomes 1.
- R4: When the reference and oscillator edges strictly alternate, steerOe stays 0 and lockOut stays 1.
- R5: A steering pulse keeps steerOe at 1 for exactly P clock cycles. P is the number of cycles between the two most recent reference edges, and it includes a reference edge that arrives on the same cycle as the slip.
- R6: lockOut is the inverse of steerOe in every cycle outside reset.
- R7: chargeOut goes to 1 on a reference edge that has no oscillator edge on the same cycle. It goes to 0 on any oscillator edge. When both edges arrive on the same cycle, chargeOut is 0, neither edge counts toward a slip, and the edge history is cleared.
- R8: A slip detected while a pulse is active restarts the pulse. The new pulse has the new polarity and a full length of P cycles.
- R9: Until two reference edges have been seen since reset, no period is known and a steering pulse lasts one cycle.
- R10: An input rising edge changes the outputs on the third clock edge after the input rises: two synchronizer stages, then one edge register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| refIn | input | 1 | Divided reference signal, asynchronous |
| vcoIn | input | 1 | Divided oscillator signal, asynchronous |
| steerOe | output | 1 | Output enable of the three-state steering pad; 0 means high impedance |
| steerLevel | output | 1 | Level driven on the steering pad while steerOe is 1: 0 means too fast, 1 means too slow |
| lockOut | output | 1 | Lock flag: 1 when locked, 0 during a slip pulse |
| chargeOut | output | 1 | Window from a reference edge to the next oscillator edge |

## Verification
The hardest situation to reach is a second slip of the opposite polarity while a first pulse is still running. Reaching it needs a precise count of the edges on each input and of the cycles between them.

The stimulus handles this with a task that places a rising edge on either input, or on both, at an exact cycle gap. A slow slip is built from back-to-back reference edges. Two oscillator edges then follow inside that pulse. The total time that steerOe is high then has a single expected value, which the stimulus computes from the gaps it chose.

Coincident edges are produced the same way. This shows that they neither slip nor leave a stale charge window.

// File: rtl/slip_pkg.sv
`timescale 1ns/1ps
package slip_pkg;

  // Edge strobes from the datapath to the control, one cycle wide.
  typedef struct packed {
    logic refRise;
    logic vcoRise;
  } edge_stb_t;

  // Slip command from the control to the datapath.
  typedef struct packed {
    logic fire;   // a slip happened this cycle
    logic fast;   // 1: oscillator side fast, 0: slow
  } slip_stb_t;

  localparam int NUM_CH  = 2;
  localparam int CH_REF  = 0;
  localparam int CH_VCO  = 1;

endpackage

// File: rtl/slip_edge_sync.sv
`timescale 1ns/1ps
module slip_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic rise
);
  // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its previous value
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[STAGES-1:0], din};
  end

  assign rise = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/slip_datapath.sv
`timescale 1ns/1ps
module slip_datapath
  import slip_pkg::*;
#(
  parameter int PW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      refIn,
  input  logic      vcoIn,
  input  slip_stb_t slipStb,
  output edge_stb_t edgeStb,
  output logic      steerOe,
  output logic      steerLevel,
  output logic      lockOut
);
  localparam logic [PW-1:0] CNT_MAX = '1;
  localparam logic [PW-1:0] ONE     = PW'(1);

  logic [NUM_CH-1:0] rawIn;
  logic [NUM_CH-1:0] riseVec;
  assign rawIn = {vcoIn, refIn};

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_ch
      slip_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rstN (rstN),
        .din  (rawIn[g]),
        .rise (riseVec[g])
      );
    end
  endgenerate

  assign edgeStb.refRise = riseVec[CH_REF];
  assign edgeStb.vcoRise = riseVec[CH_VCO];

  // Reference period meter
  logic [PW-1:0] refCnt;
  logic [PW-1:0] refPeriod;
  logic          refValid;
  logic [PW-1:0] cntPlus;

  assign cntPlus = (refCnt == CNT_MAX) ? CNT_MAX : refCnt + ONE;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refCnt    <= '0;
      refPeriod <= '0;
      refValid  <= 1'b0;
    end else if (riseVec[CH_REF]) begin
      refCnt   <= '0;
      refValid <= 1'b1;
      if (refValid) refPeriod <= cntPlus;
    end else if (refCnt != CNT_MAX) begin
      refCnt <= refCnt + ONE;
    end
  end

  // Pulse length: newest interval, at least one cycle
  logic [PW-1:0] loadRaw;
  logic [PW-1:0] loadVal;
  assign loadRaw = (riseVec[CH_REF] && refValid) ? cntPlus : refPeriod;
  assign loadVal = (loadRaw == '0) ? ONE : loadRaw;

  // Steering pulse timer
  logic [PW-1:0] pulseTimer;
  logic          levelQ;
  logic          lockQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseTimer <= '0;
      levelQ     <= 1'b0;
      lockQ      <= 1'b1;
    end else if (slipStb.fire) begin
      pulseTimer <= loadVal;
      levelQ     <= ~slipStb.fast;
      lockQ      <= 1'b0;
    end else begin
      if (pulseTimer != '0) pulseTimer <= pulseTimer - ONE;
      lockQ <= (pulseTimer <= ONE);
    end
  end

  assign steerOe    = (pulseTimer != '0);
  assign steerLevel = levelQ;
  assign lockOut    = lockQ;
endmodule

// File: rtl/slip_control.sv
`timescale 1ns/1ps
module slip_control
  import slip_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  edge_stb_t edgeStb,
  output slip_stb_t slipStb,
  output logic      chargeOut
);
  logic refSeen;   // reference edge seen since last oscillator edge
  logic vcoSeen;   // oscillator edge seen since last reference edge
  logic chargeQ;
  logic refOnly;
  logic vcoOnly;
  logic bothEdges;

  assign refOnly   = edgeStb.refRise & ~edgeStb.vcoRise;
  assign vcoOnly   = edgeStb.vcoRise & ~edgeStb.refRise;
  assign bothEdges = edgeStb.refRise &  edgeStb.vcoRise;

  always_comb begin
    slipStb.fire = (vcoOnly & vcoSeen) | (refOnly & refSeen);
    slipStb.fast = vcoOnly & vcoSeen;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refSeen <= 1'b0;
      vcoSeen <= 1'b0;
      chargeQ <= 1'b0;
    end else begin
      if (bothEdges) begin
        refSeen <= 1'b0;
        vcoSeen <= 1'b0;
      end else if (refOnly) begin
        refSeen <= 1'b1;
        vcoSeen <= 1'b0;
      end else if (vcoOnly) begin
        vcoSeen <= 1'b1;
        refSeen <= 1'b0;
      end
      if (edgeStb.vcoRise)      chargeQ <= 1'b0;
      else if (edgeStb.refRise) chargeQ <= 1'b1;
    end
  end

  assign chargeOut = chargeQ;
endmodule

// File: rtl/pll_slip_monitor.sv
`timescale 1ns/1ps
module pll_slip_monitor
  import slip_pkg::*;
#(
  parameter int PW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic refIn,
  input  logic vcoIn,
  output logic steerOe,
  output logic steerLevel,
  output logic lockOut,
  output logic chargeOut
);
  edge_stb_t edgeStb;
  slip_stb_t slipStb;

  slip_datapath #(.PW(PW), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .refIn      (refIn),
    .vcoIn      (vcoIn),
    .slipStb    (slipStb),
    .edgeStb    (edgeStb),
    .steerOe    (steerOe),
    .steerLevel (steerLevel),
    .lockOut    (lockOut)
  );

  slip_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .edgeStb   (edgeStb),
    .slipStb   (slipStb),
    .chargeOut (chargeOut)
  );
endmodule

// File: rtl/pll_slip_monitor_chk.sv
`timescale 1ns/1ps
module pll_slip_monitor_chk (
  input logic clk,
  input logic rstN,
  input logic refRise,
  input logic vcoRise,
  input logic slipFire,
  input logic slipFast,
  input logic steerOe,
  input logic steerLevel,
  input logic lockOut,
  input logic chargeOut
);
  p_fast_slip_r2: assert property (@(posedge clk) disable iff (!rstN)
    (slipFire && slipFast) |=> (steerOe && !steerLevel));

  p_slow_slip_r3: assert property (@(posedge clk) disable iff (!rstN)
    (slipFire && !slipFast) |=> (steerOe && steerLevel));

  p_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!slipFire && !steerOe) |=> !steerOe);

  p_lock_mirror_r6: assert property (@(posedge clk) disable iff (!rstN)
    (lockOut != steerOe));

  p_charge_open_r7: assert property (@(posedge clk) disable iff (!rstN)
    (refRise && !vcoRise) |=> chargeOut);

  p_charge_close_r7: assert property (@(posedge clk) disable iff (!rstN)
    vcoRise |=> !chargeOut);

  p_coincide_r7: assert property (@(posedge clk) disable iff (!rstN)
    (refRise && vcoRise) |-> !slipFire);

  p_level_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (steerOe && !slipFire) |=> $stable(steerLevel));
endmodule

bind pll_slip_monitor pll_slip_monitor_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .refRise    (edgeStb.refRise),
  .vcoRise    (edgeStb.vcoRise),
  .slipFire   (slipStb.fire),
  .slipFast   (slipStb.fast),
  .steerOe    (steerOe),
  .steerLevel (steerLevel),
  .lockOut    (lockOut),
  .chargeOut  (chargeOut)
);

// File: tb/pll_slip_monitor_tb.sv
`timescale 1ns/1ps
module pll_slip_monitor_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refIn = 1'b0;
  logic vcoIn = 1'b0;
  logic steerOe, steerLevel, lockOut, chargeOut;

  int checks = 0;
  int failures = 0;
  int oeCycles = 0;
  int lockMismatch = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pll_slip_monitor u_dut (
    .clk(clk), .rstN(rstN), .refIn(refIn), .vcoIn(vcoIn),
    .steerOe(steerOe), .steerLevel(steerLevel),
    .lockOut(lockOut), .chargeOut(chargeOut)
  );

  // Background counters sampled at the rising edge (values of the past cycle)
  always @(posedge clk) begin
    if (rstN && steerOe) oeCycles++;
    if (rstN && (lockOut == steerOe)) lockMismatch++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; refIn = 1'b0; vcoIn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    oeCycles = 0;
  endtask

  // Rising edge on the chosen inputs now, next edge may come gap cycles later
  task automatic fire(input bit r, input bit v, input int gap);
    if (r) refIn = 1'b1;
    if (v) vcoIn = 1'b1;
    repeat (2) @(negedge clk);
    refIn = 1'b0; vcoIn = 1'b0;
    repeat (gap - 2) @(negedge clk);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 steerOe in reset", steerOe, 0);
    check("R1 lockOut in reset", lockOut, 1);
    check("R1 chargeOut in reset", chargeOut, 0);
    doReset();
    check("R1 steerOe after reset", steerOe, 0);
    check("R1 lockOut after reset", lockOut, 1);
  endtask

  task automatic testLocked();
    doReset();
    for (int i = 0; i < 4; i++) begin
      fire(1, 0, 8);
      check("R7 charge open after ref edge", chargeOut, 1);
      fire(0, 1, 12);
      check("R7 charge closed after vco edge", chargeOut, 0);
    end
    check("R4 no steering while alternating", oeCycles, 0);
    check("R4 lock high while alternating", lockOut, 1);
  endtask

  task automatic testLatency();
    doReset();
    refIn = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 charge still low after two edges", chargeOut, 0);
    @(negedge clk);
    check("R10 charge high after third edge", chargeOut, 1);
    refIn = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic testFast();
    doReset();
    fire(1, 0, 10);
    fire(0, 1, 10);
    fire(1, 0, 5);
    fire(0, 1, 5);
    fire(0, 1, 4);
    check("R2 fast slip drives steer", steerOe, 1);
    check("R2 fast slip level low", steerLevel, 0);
    check("R6 lock low during fast slip", lockOut, 0);
    repeat (40) @(negedge clk);
    check("R5 fast pulse length", oeCycles, 20);
    check("R6 lock back high", lockOut, 1);
  endtask

  task automatic testSlow();
    doReset();
    fire(1, 0, 15);
    fire(0, 1, 15);
    fire(1, 0, 30);
    fire(1, 0, 4);
    check("R3 slow slip drives steer", steerOe, 1);
    check("R3 slow slip level high", steerLevel, 1);
    repeat (50) @(negedge clk);
    check("R5 slow pulse length", oeCycles, 30);
  endtask

  task automatic testRetrigger();
    doReset();
    fire(1, 0, 10);
    fire(1, 0, 3);
    check("R8 first pulse slow", steerLevel, 1);
    fire(0, 1, 3);
    fire(0, 1, 4);
    check("R8 retrigger steer active", steerOe, 1);
    check("R8 retrigger polarity fast", steerLevel, 0);
    repeat (40) @(negedge clk);
    check("R8 retrigger total length", oeCycles, 16);
  endtask

  task automatic testEarly();
    doReset();
    fire(1, 0, 5);
    fire(0, 1, 5);
    fire(0, 1, 20);
    check("R9 one-cycle pulse before period known", oeCycles, 1);
  endtask

  task automatic testCoincide();
    doReset();
    fire(1, 0, 10);
    check("R7 charge open before coincidence", chargeOut, 1);
    fire(1, 1, 10);
    check("R7 coincident edges close charge", chargeOut, 0);
    fire(1, 1, 10);
    fire(0, 1, 10);
    check("R7 coincident edges never slip", oeCycles, 0);
  endtask

  initial begin
    testReset();
    testLocked();
    testLatency();
    testFast();
    testSlow();
    testRetrigger();
    testEarly();
    testCoincide();
    check("R6 lock inverse of steer in every cycle", lockMismatch, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule